// File: doc/BRIEF.md
# Row-Scanned Pixel Matrix Controller

This block scans a square pixel detector one row at a time. It drives a one-hot row select. Each row is held for a fixed slot of clock cycles, and the rows advance in ascending order, wrapping from the last row back to the first. Within each slot, one cycle is marked by a check strobe. The column response bus is read only in that cycle.

When any column reads high on a strobed cycle, the block latches the active row number and the lowest-numbered high column. It holds both values as the marker position. Downstream logic can show these values on two decimal digits, or use the strobe and the row index to run its own trace detection.

The default matrix is 10 by 10 with a four-cycle slot, and the strobe falls on the third cycle of the slot. All outputs are registered, and the reset is synchronous.

Top module: `row_scan_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it is released, row_sel_o is 1 (bit 0 set), row_idx_o is 0, check_o is 0, and mark_row_o and mark_col_o are both 0.
- R2: row_sel_o always has exactly one bit set. That bit is bit i when row_idx_o equals i, where row_idx_o is the row number in binary.
- R3: Each row stays selected for exactly 4 consecutive cycles. Rows then advance in the order 0, 1, ..., 9 and wrap from 9 back to 0.
- R4: check_o is high on exactly one cycle per row slot, the third cycle of the slot (cycle index 2 counting from 0), and low on the other three cycles.
- R5: If check_o is high and col_i is nonzero, then from the next cycle mark_row_o equals the row that was selected and mark_col_o equals the index of the lowest set bit of col_i. Bit j of col_i stands for column j.
- R6: col_i is ignored on cycles where check_o is low, and the marker outputs do not change on those cycles.
- R7: A strobed cycle with col_i equal to zero leaves mark_row_o and mark_col_o at their previous values.
- R8: Asserting reset in the middle of a scan returns all outputs to the state of R1, and the scan restarts at row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_i | input | 10 | Column response of the selected row, bit j = column j |
| row_sel_o | output | 10 | One-hot row select, bit i = row i |
| row_idx_o | output | 4 | Binary number of the selected row |
| check_o | output | 1 | Sample strobe, high on the third cycle of each slot |
| mark_row_o | output | 4 | Row of the last detected marker, binary 0 to 9 |
| mark_col_o | output | 4 | Column of the last detected marker, binary 0 to 9 |

## Verification
The marker capture is driven with several column patterns:
- A single high column shows that row and column are taken from the correct slot.
- Several high columns, including a mask with four scattered bits, show that the lowest column wins.
- A pattern in the last row and one in row 0 cover the wrap of the scan.

An all-zero strobed row tells hold apart from clear. A row driven fully high on every cycle except the strobe shows that off-strobe samples are ignored. A reset issued mid-scan, followed by a full frame of row and strobe checks, shows that the scan restarts cleanly.

// File: rtl/row_scan_ctrl.sv
module row_scan_ctrl #(
  parameter int ROWS  = 10,
  parameter int COLS  = 10,
  parameter int SLOT  = 4,
  parameter int CHECK = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [COLS-1:0]          col_i,
  output logic [ROWS-1:0]          row_sel_o,
  output logic [$clog2(ROWS)-1:0]  row_idx_o,
  output logic                     check_o,
  output logic [$clog2(ROWS)-1:0]  mark_row_o,
  output logic [$clog2(COLS)-1:0]  mark_col_o
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam int PW = (SLOT > 1) ? $clog2(SLOT) : 1;
  localparam logic [PW-1:0] LAST_PH  = PW'(SLOT - 1);
  localparam logic [PW-1:0] CHECK_PH = PW'(CHECK);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic [CW-1:0] hit_col;
  logic          any_hit;
  logic          slot_end;

  assign slot_end = (phase_q == LAST_PH);
  assign phase_d  = slot_end ? '0 : phase_q + 1'b1;
  assign any_hit  = |col_i;

  always_comb begin
    hit_col = '0;
    for (int j = COLS - 1; j >= 0; j--)
      if (col_i[j]) hit_col = CW'(j);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= '0;
      row_idx_o <= '0;
      row_sel_o <= ROWS'(1);
      check_o   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      check_o <= (phase_d == CHECK_PH);
      if (slot_end) begin
        row_idx_o <= (row_idx_o == LAST_ROW) ? '0 : row_idx_o + 1'b1;
        row_sel_o <= {row_sel_o[ROWS-2:0], row_sel_o[ROWS-1]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_row_o <= '0;
      mark_col_o <= '0;
    end else if (check_o && any_hit) begin
      mark_row_o <= row_idx_o;
      mark_col_o <= hit_col;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(row_sel_o) == 1 && row_idx_o <= LAST_ROW);  // R2
  AST_ROW_SLOT: assert property (@(posedge clk) disable iff (rst)
    (row_idx_o != $past(row_idx_o)) |-> ($past(phase_q) == LAST_PH));  // R3
  AST_CHECK_PHASE: assert property (@(posedge clk) disable iff (rst)
    check_o |-> (phase_q == CHECK_PH));  // R4
  AST_MARK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (check_o && any_hit) |=> (mark_row_o == $past(row_idx_o)));  // R5
  AST_MARK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !check_o |=> ($stable(mark_row_o) && $stable(mark_col_o)));  // R6
  AST_MARK_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (check_o && !any_hit) |=> ($stable(mark_row_o) && $stable(mark_col_o)));  // R7
endmodule

// File: tb/row_scan_ctrl_test.sv
module row_scan_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] col_i = '0;
  logic [9:0] row_sel_o;
  logic [3:0] row_idx_o, mark_row_o, mark_col_o;
  logic       check_o;

  int n_vec = 0;
  int n_bad = 0;
  int mph = 0, mrow = 0, emr = 0, emc = 0;

  always #2 clk = ~clk;

  row_scan_ctrl uut (
    .clk(clk), .rst(rst), .col_i(col_i), .row_sel_o(row_sel_o),
    .row_idx_o(row_idx_o), .check_o(check_o),
    .mark_row_o(mark_row_o), .mark_col_o(mark_col_o)
  );

  // row, mask, drive on strobe too, expected row, expected col
  localparam logic [22:0] VEC [8] = '{
    {4'd3, 10'h010, 1'b1, 4'd3, 4'd4},
    {4'd7, 10'h300, 1'b1, 4'd7, 4'd8},
    {4'd9, 10'h001, 1'b1, 4'd9, 4'd0},
    {4'd2, 10'h000, 1'b1, 4'd9, 4'd0},
    {4'd5, 10'h3FF, 1'b0, 4'd9, 4'd0},
    {4'd0, 10'h2A4, 1'b1, 4'd0, 4'd2},
    {4'd6, 10'h200, 1'b1, 4'd6, 4'd9},
    {4'd1, 10'h0C0, 1'b0, 4'd6, 4'd9}
  };

  function automatic int lowest(input logic [9:0] m);
    for (int j = 0; j < 10; j++) if (m[j]) return j;
    return -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_scan();
    chk("R2 row_sel", int'(row_sel_o), 1 << mrow);
    chk("R3 row_idx", int'(row_idx_o), mrow);
    chk("R4 check", int'(check_o), (mph == 2) ? 1 : 0);
    chk("R6 mark_row", int'(mark_row_o), emr);
    chk("R6 mark_col", int'(mark_col_o), emc);
  endtask

  task automatic step();
    if (mph == 2 && col_i != 0) begin
      emr = mrow;
      emc = lowest(col_i);
    end
    @(posedge clk); #1;
    if (mph == 3) begin
      mph = 0;
      mrow = (mrow + 1) % 10;
    end else mph++;
    check_scan();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    col_i = '0;
    repeat (3) @(posedge clk);
    #1;
    mph = 0; mrow = 0; emr = 0; emc = 0;
    chk("R1 row_sel", int'(row_sel_o), 1);
    chk("R1 row_idx", int'(row_idx_o), 0);
    chk("R1 check", int'(check_o), 0);
    chk("R1 mark_row", int'(mark_row_o), 0);
    chk("R1 mark_col", int'(mark_col_o), 0);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    for (int v = 0; v < 8; v++) begin
      int r, all;
      logic [9:0] m;
      r = int'(VEC[v][22:19]);
      m = VEC[v][18:9];
      all = int'(VEC[v][8]);
      col_i = (mrow == r && (all == 1 || mph != 2)) ? m : '0;
      step();
      while (!(mrow == r && mph == 3)) begin
        col_i = (mrow == r && (all == 1 || mph != 2)) ? m : '0;
        step();
      end
      col_i = '0;
      chk("R5/R7 table mark_row", int'(mark_row_o), int'(VEC[v][7:4]));
      chk("R5/R7 table mark_col", int'(mark_col_o), int'(VEC[v][3:0]));
    end
    // R8: reset in the middle of a scan
    repeat (6) step();
    do_reset();
    chk("R8 mark_row after reset", int'(mark_row_o), 0);
    for (int k = 0; k < 44; k++) step();
    chk("R8 restart row", int'(row_idx_o), 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule